// File: doc/BRIEF.md
# Triggered Sample Capture FIFO

This block snapshots the present output word of a filter into an eight-slot queue whenever a chosen trigger fires. The trigger can be one of three timer pulses or the filter's own new-output strobe. A software load command can also serve as the trigger. Software reads the queue one word at a time through a pop port. It watches a single 16-bit control and status word, which reports the fill count and a sticky overflow flag.

An interrupt line can be raised when the fill count reaches a programmed level, when a capture has been lost to a full queue, or both. The interrupt is gated by an enable input. The overflow flag can be cleared only by reset or by a dedicated clear pulse. All outputs come from registers, and all state is cleared by a synchronous active-high reset.

Top module: `trig_capture_fifo`

## Requirements
- R1: The queue holds up to 8 words. Bits 11:8 of the status word report the count from 0 to 8, and a count of 8 means full.
- R2: Bits 15:12 hold a level L. When L is nonzero and the count is at least L, the level condition is true. L = 0 turns the level condition off.
- R3: A capture that arrives while the queue is full, with no pop in the same cycle, is dropped. It sets bit 7 (overflow). That bit stays set until reset or an `ovf_clr` pulse, and a new overflow in the same cycle as `ovf_clr` leaves it set.
- R4: Bits 2:0 select the trigger. The codes are 0, 1 and 2 for timer pulses 0, 1 and 2, 6 for every `filt_rdy` strobe, and 7 for the software load. Codes 3, 4 and 5 cause no captures, and strobes from unselected sources are ignored.
- R5: A register write with bit 3 set captures `filt_data`, but only when the stored select is 7. Bit 3 and bits 6:4 always read 0.
- R6: `irq` equals `irq_en` AND (level condition OR overflow flag), registered one cycle after the state it reflects.
- R7: After reset the status word reads 0x0007, the queue is empty, and `pop_data` and `irq` are 0.
- R8: A `pop` returns the oldest word on `pop_data` after the clock edge. A pop on an empty queue returns 0 and leaves the count unchanged.
- R9: A capture and a pop in the same cycle leave the count unchanged and keep first-in first-out order. This holds even when the queue is full, and then no overflow is set.
- R10: A write updates only bits 15:12 and 2:0, and writes to the count and overflow bits are ignored. `reg_rdata` shows the state one cycle after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Registered control and status word |
| pop | input | 1 | Pop the oldest queued word |
| pop_data | output | DATA_W | Word returned by the last pop |
| filt_data | input | DATA_W | Present filter output word |
| filt_rdy | input | 1 | Filter new-output strobe |
| tmr_pulse | input | NUM_TMR | Timer trigger pulses |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Three pairs of events can land in one cycle. A capture and a pop can fall together, once on a half-full queue and once on a full queue. An overflow capture can also coincide with an `ovf_clr` pulse. The bench drives each pair in a single cycle. It then judges the outcome through the popped word, the count field, and whether the overflow bit and `irq` are set or clear. A full-queue pop plus capture must keep the count at 8 with no overflow. The overflow-plus-clear case must leave the flag set.

// File: rtl/capture_pkg.sv
package capture_pkg;
  localparam int REG_W = 16;
  localparam int LVL_W = 4;
  localparam int SRC_W = 3;

  localparam logic [SRC_W-1:0] SRC_TMR0 = 3'd0;
  localparam logic [SRC_W-1:0] SRC_FILT = 3'd6;
  localparam logic [SRC_W-1:0] SRC_SW   = 3'd7;

  localparam logic [SRC_W-1:0] SRC_RESET = SRC_SW;
endpackage

// File: rtl/capture_trig_sel.sv
module capture_trig_sel
  import capture_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input  logic [SRC_W-1:0]   src,
  input  logic [NUM_TMR-1:0] tmr_pulse,
  input  logic               filt_rdy,
  input  logic               sw_load,
  output logic               push_req
);
  logic [NUM_TMR-1:0] tmr_hit;

  // one comparator per timer input
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign tmr_hit[t] = tmr_pulse[t] && (src == SRC_TMR0 + SRC_W'(t));
  end

  always_comb begin
    push_req = |tmr_hit;
    if (src == SRC_FILT) push_req = filt_rdy;
    if (src == SRC_SW)   push_req = sw_load;
  end
endmodule

// File: rtl/capture_ctrl_regs.sv
module capture_ctrl_regs
  import capture_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             ovf,
  output logic [LVL_W-1:0] lvl,
  output logic [SRC_W-1:0] src,
  output logic             sw_load,
  output logic [REG_W-1:0] reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
      src <= SRC_RESET;
    end else if (reg_wr) begin
      lvl <= reg_wdata[15:12];
      src <= reg_wdata[2:0];
    end
  end

  // load command acts on the select already stored
  assign sw_load = reg_wr && reg_wdata[3];

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= {{(REG_W-SRC_W){1'b0}}, SRC_RESET};
    else     reg_rdata <= {lvl, LVL_W'(count), ovf, 4'b0000, src};
  end
endmodule

// File: rtl/capture_fifo_core.sv
module capture_fifo_core #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, empty, do_pop, do_push;

  assign full    = (count == FULL);
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rdata  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (pop)     rdata  <= do_pop ? mem[rd_ptr] : '0;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full && !do_pop) ovf <= 1'b1;
      else if (ovf_clr)            ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_capture_fifo.sv
module trig_capture_fifo
  import capture_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               pop,
  output logic [DATA_W-1:0]  pop_data,
  input  logic [DATA_W-1:0]  filt_data,
  input  logic               filt_rdy,
  input  logic [NUM_TMR-1:0] tmr_pulse,
  input  logic               ovf_clr,
  input  logic               irq_en,
  output logic               irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] lvl;
  logic [SRC_W-1:0] src;
  logic             sw_load, push_req, fifo_ovf, lvl_hit;
  logic [CNT_W-1:0] fifo_count;

  capture_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .count(fifo_count), .ovf(fifo_ovf), .lvl(lvl), .src(src),
    .sw_load(sw_load), .reg_rdata(reg_rdata)
  );

  capture_trig_sel #(.NUM_TMR(NUM_TMR)) u_trig (
    .src(src), .tmr_pulse(tmr_pulse), .filt_rdy(filt_rdy),
    .sw_load(sw_load), .push_req(push_req)
  );

  capture_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push_req), .wdata(filt_data), .pop(pop),
    .ovf_clr(ovf_clr), .rdata(pop_data), .count(fifo_count), .ovf(fifo_ovf)
  );

  assign lvl_hit = (lvl != '0) && (LVL_W'(fifo_count) >= lvl);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && (lvl_hit || fifo_ovf);
  end
endmodule

// File: rtl/capture_fifo_chk.sv
module capture_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_en,
  input logic              irq,
  input logic              pop,
  input logic [DATA_W-1:0] pop_data,
  input logic              ovf_clr,
  input logic [CNT_W-1:0]  count,
  input logic              ovf,
  input logic [15:0]       reg_rdata
);
  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |=> (pop_data == '0 && count == '0));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[6:3] == 4'b0000);
endmodule

bind trig_capture_fifo capture_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_en(irq_en), .irq(irq), .pop(pop),
  .pop_data(pop_data), .ovf_clr(ovf_clr), .count(fifo_count),
  .ovf(fifo_ovf), .reg_rdata(reg_rdata)
);

// File: tb/tb_trig_capture_fifo.sv
`timescale 1ns/1ps
module tb_trig_capture_fifo;
  logic        clk = 0, rst = 1, reg_wr = 0, pop = 0, filt_rdy = 0;
  logic        ovf_clr = 0, irq_en = 0, irq;
  logic [15:0] reg_wdata = 0, reg_rdata, pop_data, filt_data = 0;
  logic [2:0]  tmr_pulse = 0;
  int errors = 0, checks = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  trig_capture_fifo dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pop(pop), .pop_data(pop_data),
    .filt_data(filt_data), .filt_rdy(filt_rdy), .tmr_pulse(tmr_pulse),
    .ovf_clr(ovf_clr), .irq_en(irq_en), .irq(irq)
  );

  // kind[33:32]: 0 sw push data, 1 pop expect, 2 push+pop expect, 3 count expect
  localparam logic [33:0] VEC [13] = '{
    {2'd0, 16'h00A1, 16'h0000}, {2'd0, 16'h00B2, 16'h0000},
    {2'd0, 16'h00C3, 16'h0000}, {2'd3, 16'h0000, 16'h0003},
    {2'd1, 16'h0000, 16'h00A1}, {2'd2, 16'h00D4, 16'h00B2},
    {2'd3, 16'h0000, 16'h0002}, {2'd1, 16'h0000, 16'h00C3},
    {2'd1, 16'h0000, 16'h00D4}, {2'd1, 16'h0000, 16'h0000},
    {2'd3, 16'h0000, 16'h0000}, {2'd0, 16'h00E5, 16'h0000},
    {2'd1, 16'h0000, 16'h00E5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic wr_reg(input logic [15:0] w);
    reg_wr = 1; reg_wdata = w; cyc(); reg_wr = 0; reg_wdata = 0;
  endtask
  task automatic rd_reg(output logic [15:0] r); cyc(); r = reg_rdata; endtask
  task automatic do_pop(output logic [15:0] d); pop = 1; cyc(); pop = 0; d = pop_data; endtask
  task automatic do_reset(); rst = 1; cyc(); cyc(); rst = 0; endtask
  task automatic filt_pulse(input logic [15:0] d);
    filt_data = d; filt_rdy = 1; cyc(); filt_rdy = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R7 reset state
    chk("R7 reg", reg_rdata, 16'h0007);
    chk("R7 pop_data", pop_data, 0);
    chk("R7 irq", irq, 0);

    // vector walk: R8 R9 R5 R1
    foreach (VEC[i]) begin
      case (VEC[i][33:32])
        2'd0: begin filt_data = VEC[i][31:16]; wr_reg(16'h000F); end
        2'd1: begin do_pop(v); chk("R8 pop order", v, VEC[i][15:0]); end
        2'd2: begin
          filt_data = VEC[i][31:16]; reg_wr = 1; reg_wdata = 16'h000F; pop = 1;
          cyc(); reg_wr = 0; reg_wdata = 0; pop = 0;
          chk("R9 push+pop data", pop_data, VEC[i][15:0]);
        end
        default: begin rd_reg(v); chk("R1 count", v[11:8], VEC[i][3:0]); end
      endcase
    end

    // R10 read-only fields ignore writes
    do_reset();
    wr_reg(16'h5FF7); rd_reg(v);
    chk("R10 readonly", v, 16'h5007);

    // R4 source selection
    do_reset();
    wr_reg(16'h0001);
    tmr_pulse = 3'b101; filt_rdy = 1; cyc(); tmr_pulse = 0; filt_rdy = 0;
    rd_reg(v); chk("R4 unselected ignored", v, 16'h0001);
    tmr_pulse = 3'b010; cyc(); tmr_pulse = 0;
    rd_reg(v); chk("R4 timer1", v, 16'h0101);
    // R5 load bit ignored when stored select is not 7
    wr_reg(16'h0009); rd_reg(v);
    chk("R5 load ignored, bit3 reads 0", v, 16'h0101);
    wr_reg(16'h0004);
    tmr_pulse = 3'b111; filt_rdy = 1; cyc(); tmr_pulse = 0; filt_rdy = 0;
    rd_reg(v); chk("R4 reserved code", v, 16'h0104);
    wr_reg(16'h0000); tmr_pulse = 3'b001; cyc(); tmr_pulse = 0;
    wr_reg(16'h0002); tmr_pulse = 3'b100; cyc(); tmr_pulse = 0;
    rd_reg(v); chk("R4 timer0 and timer2", v, 16'h0302);

    // R2 R6 level interrupt
    do_reset();
    irq_en = 1;
    wr_reg(16'h3007);
    filt_data = 16'h0011; wr_reg(16'h300F);
    filt_data = 16'h0022; wr_reg(16'h300F);
    rd_reg(v); chk("R2 count 2", v, 16'h3207);
    chk("R2 below level", irq, 0);
    filt_data = 16'h0033; wr_reg(16'h300F);
    rd_reg(v); chk("R2 count 3", v, 16'h3307);
    chk("R2 level reached", irq, 1);
    irq_en = 0; cyc();
    chk("R6 irq gated", irq, 0);
    irq_en = 1; wr_reg(16'h0007); cyc(); cyc();
    chk("R2 level zero disables", irq, 0);

    // R1 R3 R9 fill, overflow, clear
    do_reset();
    irq_en = 1;
    wr_reg(16'h0006);
    for (int k = 0; k < 8; k++) filt_pulse(16'h0100 + 16'(k));
    rd_reg(v); chk("R1 full count", v, 16'h0806);
    chk("R6 no irq when full, level 0", irq, 0);
    filt_data = 16'h01AA; filt_rdy = 1; pop = 1; cyc(); filt_rdy = 0; pop = 0;
    chk("R9 full push+pop data", pop_data, 16'h0100);
    rd_reg(v); chk("R9 full push+pop no overflow", v, 16'h0806);
    filt_pulse(16'h01BB);
    rd_reg(v); chk("R3 overflow set", v, 16'h0886);
    chk("R6 overflow irq", irq, 1);
    filt_data = 16'h01CC; filt_rdy = 1; ovf_clr = 1; cyc(); filt_rdy = 0; ovf_clr = 0;
    rd_reg(v); chk("R3 set wins over clear", v, 16'h0886);
    ovf_clr = 1; cyc(); ovf_clr = 0;
    rd_reg(v); chk("R3 cleared by pulse", v, 16'h0806);
    chk("R6 irq drops", irq, 0);
    for (int k = 1; k < 8; k++) begin
      do_pop(v); chk("R3 surviving order", v, 16'h0100 + 16'(k));
    end
    do_pop(v); chk("R9 late entry kept", v, 16'h01AA);
    rd_reg(v); chk("R8 drained", v, 16'h0006);
    do_pop(v); chk("R8 empty pop zero", v, 0);

    finish_run();
  end
endmodule